// File: doc/BRIEF.md
# Differential Demodulator Rotation and Frequency-Loop Input Stage

This block sits at the front of a differential phase demodulator datapath for BPSK, QPSK and π/4-QPSK. On each symbol strobe it stores the incoming I and Q pair as the reference symbol. It presents that stored symbol, rotated by 0°, +45° or −45°, to the phase decision logic downstream. Pure BPSK and π/4-QPSK normally run without rotation. Conventional QPSK normally uses the −45° setting.

The second path is for frequency correction. A 4-bit shift code picks eight consecutive bits out of a 17-bit frequency-discriminator word, which equals the word divided by a power of two, and drives them to a loop filter. The block also holds that loop filter's integral accumulator. On each symbol strobe while the receiver is enabled, the accumulator adds the selected byte as a signed value and saturates at its limits. When the receiver is switched off, a control bit decides whether the accumulator is cleared or keeps its value for the next burst.

Top module: `diffdemod_front`

## Requirements
- R1: While reset is asserted and right after it, the stored symbol is zero, so both rotated outputs read 0 for every rotation code, and the accumulator output reads 0.
- R2: The stored symbol loads `i_in`/`q_in` at a clock edge where `sym_stb` is 1. With `sym_stb` at 0 it holds, and `i_rot_out`/`q_rot_out` stay unchanged while `rot_ctrl` is unchanged.
- R3: With `rot_ctrl[1]` = 0 (codes 00 and 01), `i_rot_out` equals the stored I and `q_rot_out` equals the stored Q, sign-extended.
- R4: With `rot_ctrl` = 10 (+45°), `i_rot_out` = I − Q and `q_rot_out` = Q + I, where I and Q are the stored symbol.
- R5: With `rot_ctrl` = 11 (−45°), `i_rot_out` = I + Q and `q_rot_out` = Q − I.
- R6: The rotated outputs are one bit wider than the inputs and signed. The sum and difference of any two input values, including −128 and +127, appear without wrap.
- R7: For `view_sel` = n with 0 ≤ n ≤ 9, `loop_in_out` equals `disc_in` bits n+7 down to n.
- R8: For `view_sel` codes 10 through 15, `loop_in_out` is 0.
- R9: At a clock edge where `sym_stb` and `rx_en` are both 1, the accumulator adds `loop_in_out` taken as a signed 8-bit value. It is unchanged at any edge where either is 0, apart from the clear in R11.
- R10: The accumulator saturates at +32767 and −32768 and never wraps.
- R11: When `keep_acc` is 0, the accumulator reads 0 after the clock edge at which `rx_en` is first seen low after being high.
- R12: When `keep_acc` is 1, the accumulator keeps its value across a high-to-low change of `rx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_stb | input | 1 | Symbol strobe, one clock per symbol |
| i_in | input | 8 | Current symbol I, signed |
| q_in | input | 8 | Current symbol Q, signed |
| rot_ctrl | input | 2 | Rotation code: 0X none, 10 +45°, 11 −45° |
| i_rot_out | output | 9 | Rotated stored-symbol I, signed |
| q_rot_out | output | 9 | Rotated stored-symbol Q, signed |
| disc_in | input | 17 | Frequency discriminator word |
| view_sel | input | 4 | Viewport shift code n |
| loop_in_out | output | 8 | Selected discriminator byte for the loop filter |
| rx_en | input | 1 | Receiver enable |
| keep_acc | input | 1 | 1: keep the accumulator when the receiver turns off |
| k2_acc_out | output | 16 | Integral accumulator, signed |

## Verification
The rotation is tested with an asymmetric mixed-sign symbol, so that an exchange of I and Q or a flipped sign shows up in every code. It is also tested with the extreme pairs (−128, −128) and (+127, −128), which show whether the extra output bit is really carried. The viewport is tested with an irregular 17-bit word across all sixteen codes. Each legal shift then produces a different byte, and a slice that is off by one bit cannot match. The accumulator is driven with a positive and a negative byte, with strobes given with the receiver disabled, and with long runs into both limits. Turning the receiver off with each setting of the keep bit separates clearing from holding.

// File: rtl/diffdemod_pkg.sv
package diffdemod_pkg;

    typedef enum logic [1:0] {
        ROT_PASS_A = 2'b00,
        ROT_PASS_B = 2'b01,
        ROT_PLUS45 = 2'b10,
        ROT_MINUS45 = 2'b11
    } rot_mode_e;

endpackage

// File: rtl/diff_rotator.sv
module diff_rotator #(
    parameter int IQ_W = 8
) (
    input  logic [IQ_W-1:0]            ref_i,
    input  logic [IQ_W-1:0]            ref_q,
    input  diffdemod_pkg::rot_mode_e   mode,
    output logic [IQ_W:0]              rot_i,
    output logic [IQ_W:0]              rot_q
);
    localparam int OUT_W = IQ_W + 1;

    logic [OUT_W-1:0] ext_i;
    logic [OUT_W-1:0] ext_q;

    assign ext_i = {ref_i[IQ_W-1], ref_i};
    assign ext_q = {ref_q[IQ_W-1], ref_q};

    always_comb begin
        unique case (mode)
            diffdemod_pkg::ROT_PLUS45: begin
                rot_i = ext_i - ext_q;
                rot_q = ext_q + ext_i;
            end
            diffdemod_pkg::ROT_MINUS45: begin
                rot_i = ext_i + ext_q;
                rot_q = ext_q - ext_i;
            end
            default: begin
                rot_i = ext_i;
                rot_q = ext_q;
            end
        endcase
    end
endmodule

// File: rtl/disc_viewport.sv
module disc_viewport #(
    parameter int DISC_W = 17,
    parameter int LOOP_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic [DISC_W-1:0] disc,
    input  logic [SEL_W-1:0]  sel,
    output logic [LOOP_W-1:0] window
);
    localparam int NUM_VIEWS = DISC_W - LOOP_W + 1;

    logic [LOOP_W-1:0] cand [NUM_VIEWS];

    for (genvar n = 0; n < NUM_VIEWS; n++) begin : g_view
        assign cand[n] = disc[n + LOOP_W - 1 -: LOOP_W];
    end

    always_comb begin
        window = '0;
        for (int k = 0; k < NUM_VIEWS; k++) begin
            if (sel == SEL_W'(k)) begin
                window = cand[k];
            end
        end
    end
endmodule

// File: rtl/k2_accum.sv
module k2_accum #(
    parameter int LOOP_W = 8,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_stb,
    input  logic              rx_en,
    input  logic              keep_acc,
    input  logic [LOOP_W-1:0] loop_in,
    output logic [ACC_W-1:0]  acc
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             en_prev;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic             turned_off;

    always_comb begin
        st_d       = st_q;
        st_d.en_prev = rx_en;
        sum        = {{(SUM_W-LOOP_W){loop_in[LOOP_W-1]}}, loop_in}
                   + {st_q.acc[ACC_W-1], st_q.acc};
        turned_off = st_q.en_prev && !rx_en;
        if (turned_off && !keep_acc) begin
            st_d.acc = '0;
        end else if (rx_en && sym_stb) begin
            if (sum[SUM_W-1] != sum[SUM_W-2]) begin
                st_d.acc = sum[SUM_W-1] ? ACC_MIN : ACC_MAX;
            end else begin
                st_d.acc = sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;
endmodule

// File: rtl/diffdemod_front.sv
module diffdemod_front #(
    parameter int IQ_W   = 8,
    parameter int DISC_W = 17,
    parameter int LOOP_W = 8,
    parameter int SEL_W  = 4,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_stb,
    input  logic [IQ_W-1:0]   i_in,
    input  logic [IQ_W-1:0]   q_in,
    input  logic [1:0]        rot_ctrl,
    output logic [IQ_W:0]     i_rot_out,
    output logic [IQ_W:0]     q_rot_out,
    input  logic [DISC_W-1:0] disc_in,
    input  logic [SEL_W-1:0]  view_sel,
    output logic [LOOP_W-1:0] loop_in_out,
    input  logic              rx_en,
    input  logic              keep_acc,
    output logic [ACC_W-1:0]  k2_acc_out
);
    typedef struct packed {
        logic [IQ_W-1:0] ref_i;
        logic [IQ_W-1:0] ref_q;
    } sym_state_t;

    sym_state_t sym_d, sym_q;
    diffdemod_pkg::rot_mode_e mode;

    // Reference symbol register: next value computed here, stored below.
    always_comb begin
        sym_d = sym_q;
        if (sym_stb) begin
            sym_d.ref_i = i_in;
            sym_d.ref_q = q_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_q <= '0;
        end else begin
            sym_q <= sym_d;
        end
    end

    assign mode = diffdemod_pkg::rot_mode_e'(rot_ctrl);

    diff_rotator #(.IQ_W(IQ_W)) rot_i (
        .ref_i (sym_q.ref_i),
        .ref_q (sym_q.ref_q),
        .mode  (mode),
        .rot_i (i_rot_out),
        .rot_q (q_rot_out)
    );

    disc_viewport #(.DISC_W(DISC_W), .LOOP_W(LOOP_W), .SEL_W(SEL_W)) view_i (
        .disc   (disc_in),
        .sel    (view_sel),
        .window (loop_in_out)
    );

    k2_accum #(.LOOP_W(LOOP_W), .ACC_W(ACC_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_stb  (sym_stb),
        .rx_en    (rx_en),
        .keep_acc (keep_acc),
        .loop_in  (loop_in_out),
        .acc      (k2_acc_out)
    );
endmodule

// File: rtl/diffdemod_front_chk.sv
module diffdemod_front_chk #(
    parameter int IQ_W   = 8,
    parameter int LOOP_W = 8,
    parameter int SEL_W  = 4,
    parameter int ACC_W  = 16,
    parameter int NUM_VIEWS = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_stb,
    input logic [1:0]        rot_ctrl,
    input logic [IQ_W:0]     i_rot_out,
    input logic [IQ_W:0]     q_rot_out,
    input logic [SEL_W-1:0]  view_sel,
    input logic [LOOP_W-1:0] loop_in_out,
    input logic              rx_en,
    input logic              keep_acc,
    input logic [ACC_W-1:0]  k2_acc_out
);
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

    assert_hold_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |=> ($stable(rot_ctrl) -> ($stable(i_rot_out) && $stable(q_rot_out))));

    assert_unused_view_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(view_sel) >= NUM_VIEWS) |-> (loop_in_out == '0));

    assert_idle_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !$past(rx_en)) |=> $stable(k2_acc_out));

    assert_sat_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && sym_stb && k2_acc_out == ACC_MAX && !loop_in_out[LOOP_W-1])
        |=> (k2_acc_out == ACC_MAX));

    assert_clear_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!keep_acc && $fell(rx_en)) |=> (k2_acc_out == '0));

    assert_keep_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_acc && $fell(rx_en)) |=> $stable(k2_acc_out));
endmodule

bind diffdemod_front diffdemod_front_chk #(
    .IQ_W(IQ_W), .LOOP_W(LOOP_W), .SEL_W(SEL_W), .ACC_W(ACC_W),
    .NUM_VIEWS(DISC_W - LOOP_W + 1)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .rot_ctrl(rot_ctrl),
    .i_rot_out(i_rot_out), .q_rot_out(q_rot_out), .view_sel(view_sel),
    .loop_in_out(loop_in_out), .rx_en(rx_en), .keep_acc(keep_acc),
    .k2_acc_out(k2_acc_out)
);

// File: tb/diffdemod_front_tb_top.sv
module diffdemod_front_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sym_stb = 1'b0;
    logic [7:0]        i_in = '0;
    logic [7:0]        q_in = '0;
    logic [1:0]        rot_ctrl = '0;
    logic [8:0]        i_rot_out;
    logic [8:0]        q_rot_out;
    logic [16:0]       disc_in = '0;
    logic [3:0]        view_sel = '0;
    logic [7:0]        loop_in_out;
    logic              rx_en = 1'b0;
    logic              keep_acc = 1'b0;
    logic [15:0]       k2_acc_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    diffdemod_front dut_i (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .i_in(i_in), .q_in(q_in),
        .rot_ctrl(rot_ctrl), .i_rot_out(i_rot_out), .q_rot_out(q_rot_out),
        .disc_in(disc_in), .view_sel(view_sel), .loop_in_out(loop_in_out),
        .rx_en(rx_en), .keep_acc(keep_acc), .k2_acc_out(k2_acc_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rot(input string req, input int ei, input int eq);
        #1;
        check(req, int'($signed(i_rot_out)), ei);
        check(req, int'($signed(q_rot_out)), eq);
    endtask

    task automatic strobe(input int si, input int sq);
        @(negedge clk);
        i_in = 8'(si); q_in = 8'(sq); sym_stb = 1'b1;
        @(negedge clk);
        sym_stb = 1'b0;
    endtask

    function automatic int clamp(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic t_reset();
        for (int c = 0; c < 4; c++) begin
            rot_ctrl = 2'(c);
            check_rot("R1", 0, 0);
        end
        check("R1", int'($signed(k2_acc_out)), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rot_ctrl = 2'b11;
        check_rot("R1", 0, 0);
        check("R1", int'($signed(k2_acc_out)), 0);
    endtask

    task automatic t_hold();
        rot_ctrl = 2'b00;
        strobe(5, -3);
        check_rot("R2", 5, -3);
        i_in = 8'd99; q_in = 8'd77;
        repeat (3) @(negedge clk);
        check_rot("R2", 5, -3);
    endtask

    task automatic t_rotate();
        strobe(20, -7);
        rot_ctrl = 2'b00; check_rot("R3", 20, -7);
        rot_ctrl = 2'b01; check_rot("R3", 20, -7);
        rot_ctrl = 2'b10; check_rot("R4", 27, 13);
        rot_ctrl = 2'b11; check_rot("R5", 13, -27);
    endtask

    task automatic t_extreme();
        strobe(-128, -128);
        rot_ctrl = 2'b10; check_rot("R6", 0, -256);
        rot_ctrl = 2'b11; check_rot("R6", -256, 0);
        strobe(127, -128);
        rot_ctrl = 2'b10; check_rot("R6", 255, -1);
        rot_ctrl = 2'b11; check_rot("R6", -1, -255);
        rot_ctrl = 2'b00; check_rot("R6", 127, -128);
    endtask

    task automatic t_view();
        disc_in = 17'h1A5C3;
        for (int n = 0; n < 16; n++) begin
            view_sel = 4'(n);
            #1;
            if (n <= 9) check("R7", int'(loop_in_out), int'((disc_in >> n) & 17'hFF));
            else        check("R8", int'(loop_in_out), 0);
        end
        disc_in = 17'h1FFFF; view_sel = 4'd12; #1;
        check("R8", int'(loop_in_out), 0);
    endtask

    task automatic t_accum();
        int exp = 0;
        view_sel = 4'd0; keep_acc = 1'b0;
        @(negedge clk); rx_en = 1'b1;
        disc_in = 17'h00005;
        repeat (3) strobe(1, 1);
        exp = 15;
        check("R9", int'($signed(k2_acc_out)), exp);
        disc_in = 17'h100FE;
        strobe(1, 1); exp = 13;
        check("R9", int'($signed(k2_acc_out)), exp);
        repeat (4) @(negedge clk);
        check("R9", int'($signed(k2_acc_out)), exp);
        keep_acc = 1'b1; rx_en = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R12", int'($signed(k2_acc_out)), exp);
        strobe(2, 2);
        check("R9", int'($signed(k2_acc_out)), exp);
        rx_en = 1'b1; disc_in = 17'h00005;
        strobe(3, 3); exp = 18;
        check("R9", int'($signed(k2_acc_out)), exp);
        keep_acc = 1'b0; rx_en = 1'b0;
        @(negedge clk);
        check("R11", int'($signed(k2_acc_out)), 0);
    endtask

    task automatic t_saturate();
        int exp = 0;
        rx_en = 1'b1; keep_acc = 1'b1; view_sel = 4'd0;
        disc_in = 17'h0007F;
        @(negedge clk); sym_stb = 1'b1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            exp = clamp(exp + 127);
        end
        sym_stb = 1'b0;
        check("R10", int'($signed(k2_acc_out)), exp);
        check("R10", int'($signed(k2_acc_out)), 32767);
        disc_in = 17'h00080;
        sym_stb = 1'b1;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            exp = clamp(exp - 128);
        end
        sym_stb = 1'b0;
        check("R10", int'($signed(k2_acc_out)), -32768);
        disc_in = 17'h00003;
        strobe(0, 0);
        check("R10", int'($signed(k2_acc_out)), -32765);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_hold();
        t_rotate();
        t_extreme();
        t_view();
        t_accum();
        t_saturate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule